// File: doc/BRIEF.md
# Port-Group Forwarding Mask Resolver

This block works out which egress ports receive a Layer 2 frame. It holds one shared table of port masks. Each mask has one bit per physical port plus one bit for the CPU port module, which sits just above the highest physical port. Every lookup reads three entries from this table and ANDs them. The first is a destination entry, picked either by the MAC table's destination index or by a flood rule for unknown destinations. The second is an aggregation entry, picked by the frame's 4-bit link aggregation code. The third is a source entry, picked by the ingress port. Its bits say which egress ports that ingress port may reach.

A request is registered on the clock edge where it is presented. The three masks are read in parallel in the next cycle, and the ANDed result leaves a register together with a valid strobe. A new request can be accepted every cycle. Software loads the table and three flood-index registers through a simple write/read register port. Reads on that port are combinational.

Top module: `pgm_resolver`

## Requirements
- R1: After reset, with port count N (default 10) and the CPU bit at position N, the table holds the following:
  - destination entry i < N holds only bit i;
  - entry 59 (CPU whitelist) holds only the CPU bit;
  - entry 60 (unknown-unicast flood set) holds every physical port bit and no CPU bit;
  - entries 61, 62 and 63 hold all bits;
  - the other destination entries hold zero;
  - aggregation entries 64..79 hold all bits;
  - source entry 80+i holds all bits except bit i.
- R2: After reset, the unicast flood-index register (config address 96) reads 60. The non-IP multicast register (address 97) and the broadcast register (address 98) each read 61. Each reads back as a 6-bit value, zero-extended.
- R3: A request presented in cycle t produces `res_valid` high, with its mask, in cycle t+2. Requests may arrive on consecutive cycles, and their results come out in order on consecutive cycles.
- R4: The result mask is the bitwise AND of the destination entry, the aggregation entry and the source entry.
- R5: When `req_hit` is 1, the destination entry is the one numbered `req_dest` (0..63).
- R6: When `req_hit` is 0, the destination entry depends on the class code:
  - class 0 (unicast) uses the value in the register at address 96;
  - class 2 (non-IP multicast) uses the register at address 97;
  - class 1 (broadcast) and the unused codes 5..7 use the register at address 98.
- R7: When `req_hit` is 0, class 3 (IPv4 multicast) always uses entry 62 and class 4 (IPv6 multicast) always uses entry 63. The flood-index registers do not affect these classes.
- R8: The aggregation entry is 64 plus `req_lac`.
- R9: The source entry is 80 plus `req_port`. An ingress port number above N yields an all-zero result mask.
- R10: At reset, unknown unicast never reaches the CPU bit. Once software sets the CPU bit in entry 60, unknown unicast does reach the CPU bit.
- R11: A lookup sees every table write presented in the same cycle as the request or earlier. A write presented in the cycle after the request does not affect that lookup, but it does affect later ones.
- R12: The config address map is as follows:
  - addresses 0..(80+N) reach table entries, with data in bits N..0;
  - addresses 96..98 reach the flood-index registers, with data in bits 5..0;
  - any other address reads zero and ignores writes.
- R13: While `rst` is high, `res_valid` goes low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_port | input | 4 | Ingress port number (CPU is N) |
| req_hit | input | 1 | Destination found in the MAC table |
| req_dest | input | 6 | Destination entry index from the MAC table |
| req_class | input | 3 | Frame class code |
| req_lac | input | 4 | Link aggregation code |
| res_valid | output | 1 | Result strobe |
| res_mask | output | 11 | Egress port mask, CPU bit at the top |
| cfg_we | input | 1 | Config write enable |
| cfg_addr | input | 7 | Config address |
| cfg_wdata | input | 11 | Config write data |
| cfg_rdata | output | 11 | Config read data (combinational) |

## Verification
The hardest case to reach from the ports is a table write that lands in the exact cycle in which a pending lookup reads that same entry. The stimulus issues a request on one falling edge and raises the write enable for that entry on the next falling edge. The lookup must then return the old mask, and a repeat request must return the new one. A companion case presents the write in the same cycle as the request and expects the new mask at once. Back-to-back requests taken from the vector table exercise the pipeline with no gaps between them.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    localparam int IDX_W     = 7;
    localparam int DST_W     = 6;
    localparam int LAC_W     = 4;
    localparam int CLS_W     = 3;

    localparam int AGGR_BASE = 64;
    localparam int SRC_BASE  = 80;

    localparam int IDX_CPU   = 59;
    localparam int IDX_UC    = 60;
    localparam int IDX_MC    = 61;
    localparam int IDX_MC4   = 62;
    localparam int IDX_MC6   = 63;

    localparam int CFG_FLOOD_UC = 96;
    localparam int CFG_FLOOD_MC = 97;
    localparam int CFG_FLOOD_BC = 98;

    typedef enum logic [CLS_W-1:0] {
        CLS_UC  = 3'd0,
        CLS_BC  = 3'd1,
        CLS_MC  = 3'd2,
        CLS_MC4 = 3'd3,
        CLS_MC6 = 3'd4
    } fclass_e;

    typedef struct packed {
        logic [DST_W-1:0] uc;
        logic [DST_W-1:0] mc;
        logic [DST_W-1:0] bc;
    } flood_sel_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] aggr;
        logic [IDX_W-1:0] src;
        logic             src_ok;
    } lookup_t;

    function automatic logic [DST_W-1:0] pick_dest(
        input logic             hit,
        input logic [DST_W-1:0] dest,
        input logic [CLS_W-1:0] cls,
        input flood_sel_t       fsel
    );
        logic [DST_W-1:0] r;
        if (hit) begin
            r = dest;
        end else begin
            case (cls)
                CLS_UC:  r = fsel.uc;
                CLS_MC:  r = fsel.mc;
                CLS_MC4: r = DST_W'(IDX_MC4);
                CLS_MC6: r = DST_W'(IDX_MC6);
                default: r = fsel.bc;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/pgm_flood_regs.sv
module pgm_flood_regs
    import pgm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IDX_W-1:0]     addr,
    input  logic [DST_W-1:0]     wdata,
    output flood_sel_t           fsel,
    output logic                 hit_addr,
    output logic [DST_W-1:0]     rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel.uc <= DST_W'(IDX_UC);
            fsel.mc <= DST_W'(IDX_MC);
            fsel.bc <= DST_W'(IDX_MC);
        end else if (we) begin
            if (addr == IDX_W'(CFG_FLOOD_UC)) fsel.uc <= wdata;
            if (addr == IDX_W'(CFG_FLOOD_MC)) fsel.mc <= wdata;
            if (addr == IDX_W'(CFG_FLOOD_BC)) fsel.bc <= wdata;
        end
    end

    always_comb begin
        hit_addr = 1'b1;
        case (addr)
            IDX_W'(CFG_FLOOD_UC): rdata = fsel.uc;
            IDX_W'(CFG_FLOOD_MC): rdata = fsel.mc;
            IDX_W'(CFG_FLOOD_BC): rdata = fsel.bc;
            default: begin
                rdata    = '0;
                hit_addr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pgm_index_gen.sv
module pgm_index_gen
    import pgm_pkg::*;
#(
    parameter int NPORT  = 10,
    parameter int PORT_W = 4
) (
    input  logic                 req_valid,
    input  logic [PORT_W-1:0]    req_port,
    input  logic                 req_hit,
    input  logic [DST_W-1:0]     req_dest,
    input  logic [CLS_W-1:0]     req_class,
    input  logic [LAC_W-1:0]     req_lac,
    input  flood_sel_t           fsel,
    output lookup_t              nxt
);

    logic port_ok;

    assign port_ok = (req_port <= PORT_W'(NPORT));

    always_comb begin
        nxt.valid  = req_valid;
        nxt.dst    = IDX_W'(pick_dest(req_hit, req_dest, req_class, fsel));
        nxt.aggr   = IDX_W'(AGGR_BASE) + IDX_W'(req_lac);
        nxt.src_ok = port_ok;
        nxt.src    = port_ok ? (IDX_W'(SRC_BASE) + IDX_W'(req_port))
                             : IDX_W'(SRC_BASE);
    end

endmodule

// File: rtl/pgm_table.sv
module pgm_table
    import pgm_pkg::*;
#(
    parameter int NPORT  = 10,
    parameter int MASK_W = NPORT + 1,
    parameter int DEPTH  = SRC_BASE + NPORT + 1,
    parameter int NRD    = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [IDX_W-1:0]              waddr,
    input  logic [MASK_W-1:0]             wdata,
    input  logic [IDX_W-1:0]              cfg_raddr,
    output logic [MASK_W-1:0]             cfg_rmask,
    input  logic [NRD-1:0][IDX_W-1:0]     rd_idx,
    output logic [NRD-1:0][MASK_W-1:0]    rd_mask
);

    localparam logic [MASK_W-1:0] CPU_BIT = MASK_W'(1) << NPORT;

    logic [MASK_W-1:0] mem [DEPTH];

    function automatic logic [MASK_W-1:0] reset_value(input int i);
        logic [MASK_W-1:0] v;
        v = '0;
        if (i < NPORT)                              v = MASK_W'(1) << i;
        else if (i == IDX_CPU)                      v = CPU_BIT;
        else if (i == IDX_UC)                       v = ~CPU_BIT;
        else if (i >= IDX_MC && i <= IDX_MC6)       v = '1;
        else if (i >= AGGR_BASE && i < SRC_BASE)    v = '1;
        else if (i >= SRC_BASE)                     v = ~(MASK_W'(1) << (i - SRC_BASE));
        return v;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= reset_value(i);
            end
        end else if (we && (waddr < IDX_W'(DEPTH))) begin
            mem[waddr] <= wdata;
        end
    end

    assign cfg_rmask = (cfg_raddr < IDX_W'(DEPTH)) ? mem[cfg_raddr] : '0;

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_mask[g] = (rd_idx[g] < IDX_W'(DEPTH)) ? mem[rd_idx[g]] : '0;
    end

endmodule

// File: rtl/pgm_resolver.sv
module pgm_resolver
    import pgm_pkg::*;
#(
    parameter int NPORT  = 10,
    parameter int MASK_W = NPORT + 1,
    parameter int PORT_W = $clog2(NPORT + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [PORT_W-1:0]    req_port,
    input  logic                 req_hit,
    input  logic [DST_W-1:0]     req_dest,
    input  logic [CLS_W-1:0]     req_class,
    input  logic [LAC_W-1:0]     req_lac,
    output logic                 res_valid,
    output logic [MASK_W-1:0]    res_mask,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_addr,
    input  logic [MASK_W-1:0]    cfg_wdata,
    output logic [MASK_W-1:0]    cfg_rdata
);

    localparam int DEPTH = SRC_BASE + NPORT + 1;
    localparam int NRD   = 3;

    flood_sel_t                   fsel;
    logic                         flood_hit;
    logic [DST_W-1:0]             flood_rdata;
    logic [MASK_W-1:0]            tbl_rdata;
    lookup_t                      s1_nxt;
    lookup_t                      s1_q;
    logic [NRD-1:0][IDX_W-1:0]    rd_idx;
    logic [NRD-1:0][MASK_W-1:0]   rd_mask;
    logic [MASK_W-1:0]            and_mask;

    pgm_flood_regs u_flood (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata[DST_W-1:0]),
        .fsel     (fsel),
        .hit_addr (flood_hit),
        .rdata    (flood_rdata)
    );

    pgm_index_gen #(.NPORT(NPORT), .PORT_W(PORT_W)) u_idx (
        .req_valid (req_valid),
        .req_port  (req_port),
        .req_hit   (req_hit),
        .req_dest  (req_dest),
        .req_class (req_class),
        .req_lac   (req_lac),
        .fsel      (fsel),
        .nxt       (s1_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= s1_nxt;
    end

    assign rd_idx[0] = s1_q.dst;
    assign rd_idx[1] = s1_q.aggr;
    assign rd_idx[2] = s1_q.src;

    pgm_table #(.NPORT(NPORT), .MASK_W(MASK_W), .DEPTH(DEPTH), .NRD(NRD)) u_tbl (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .waddr     (cfg_addr),
        .wdata     (cfg_wdata),
        .cfg_raddr (cfg_addr),
        .cfg_rmask (tbl_rdata),
        .rd_idx    (rd_idx),
        .rd_mask   (rd_mask)
    );

    always_comb begin
        and_mask = '1;
        for (int k = 0; k < NRD; k++) begin
            and_mask = and_mask & rd_mask[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_mask  <= '0;
        end else begin
            res_valid <= s1_q.valid;
            if (s1_q.valid) res_mask <= s1_q.src_ok ? and_mask : '0;
        end
    end

    assign cfg_rdata = flood_hit ? MASK_W'(flood_rdata) : tbl_rdata;

endmodule

// File: rtl/pgm_checker.sv
module pgm_checker
    import pgm_pkg::*;
#(
    parameter int NPORT  = 10,
    parameter int MASK_W = NPORT + 1,
    parameter int PORT_W = $clog2(NPORT + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [PORT_W-1:0]    req_port,
    input logic                 req_hit,
    input logic [DST_W-1:0]     req_dest,
    input logic [CLS_W-1:0]     req_class,
    input logic                 res_valid,
    input logic [MASK_W-1:0]    res_mask,
    input logic [IDX_W-1:0]     s1_dst
);

    AST_RESULT_HAS_REQUEST: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(req_valid, 2)); // R3

    AST_REQUEST_GIVES_RESULT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> ##1 res_valid); // R3

    AST_HIT_SELECTS_DEST: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_hit) |=> (s1_dst == {1'b0, $past(req_dest)})); // R5

    AST_IPV4_FIXED_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_hit && req_class == 3'd3) |=> (s1_dst == 7'd62)); // R7

    AST_IPV6_FIXED_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_hit && req_class == 3'd4) |=> (s1_dst == 7'd63)); // R7

    AST_BAD_PORT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_port > PORT_W'(NPORT)) |=> ##1 (res_mask == '0)); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> !res_valid); // R13

endmodule

bind pgm_resolver pgm_checker #(.NPORT(NPORT), .MASK_W(MASK_W), .PORT_W(PORT_W)) u_pgm_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_port  (req_port),
    .req_hit   (req_hit),
    .req_dest  (req_dest),
    .req_class (req_class),
    .res_valid (res_valid),
    .res_mask  (res_mask),
    .s1_dst    (s1_q.dst)
);

// File: tb/test_pgm_resolver.sv
`timescale 1ns/100ps
module test_pgm_resolver;

    localparam int NPORT  = 10;
    localparam int MASK_W = 11;

    typedef struct packed {
        logic [3:0]  port;
        logic        hit;
        logic [5:0]  dest;
        logic [2:0]  cls;
        logic [3:0]  lac;
        logic [10:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{4'd2,  1'b1, 6'd5,  3'd0, 4'd0,  11'h020, 8'd5},  // R5 hit on port entry
        '{4'd5,  1'b1, 6'd5,  3'd0, 4'd0,  11'h000, 8'd9},  // R9 no reflection
        '{4'd0,  1'b0, 6'd0,  3'd0, 4'd1,  11'h3FE, 8'd10}, // R10 UC flood no CPU
        '{4'd3,  1'b0, 6'd0,  3'd1, 4'd2,  11'h7F7, 8'd6},  // R6 broadcast
        '{4'd10, 1'b0, 6'd0,  3'd3, 4'd3,  11'h3FF, 8'd7},  // R7 IPv4 from CPU
        '{4'd1,  1'b0, 6'd0,  3'd4, 4'd4,  11'h7FD, 8'd7},  // R7 IPv6
        '{4'd4,  1'b1, 6'd59, 3'd0, 4'd5,  11'h400, 8'd1},  // R1 CPU whitelist
        '{4'd4,  1'b1, 6'd20, 3'd0, 4'd6,  11'h000, 8'd1},  // R1 empty entry
        '{4'd7,  1'b0, 6'd0,  3'd2, 4'd7,  11'h77F, 8'd6},  // R6 non-IP multicast
        '{4'd11, 1'b1, 6'd3,  3'd0, 4'd8,  11'h000, 8'd9},  // R9 bad port
        '{4'd6,  1'b0, 6'd0,  3'd5, 4'd9,  11'h7BF, 8'd6},  // R6 unused code
        '{4'd8,  1'b1, 6'd9,  3'd0, 4'd15, 11'h200, 8'd8}   // R8 last aggr entry
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [3:0]        req_port = '0;
    logic              req_hit = 1'b0;
    logic [5:0]        req_dest = '0;
    logic [2:0]        req_class = '0;
    logic [3:0]        req_lac = '0;
    logic              res_valid;
    logic [MASK_W-1:0] res_mask;
    logic              cfg_we = 1'b0;
    logic [6:0]        cfg_addr = '0;
    logic [MASK_W-1:0] cfg_wdata = '0;
    logic [MASK_W-1:0] cfg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pgm_resolver #(.NPORT(NPORT)) i_pgm_resolver (
        .clk, .rst, .req_valid, .req_port, .req_hit, .req_dest, .req_class,
        .req_lac, .res_valid, .res_mask, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_req(input logic [3:0] p, input logic h, input logic [5:0] d,
                             input logic [2:0] c, input logic [3:0] l);
        req_valid = 1'b1; req_port = p; req_hit = h;
        req_dest = d; req_class = c; req_lac = l;
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic [MASK_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input string tag, input logic [6:0] a, input logic [MASK_W-1:0] e);
        @(negedge clk);
        cfg_addr = a;
        #0.5;
        check(tag, 32'(cfg_rdata), 32'(e));
    endtask

    task automatic lookup(input string tag, input logic [3:0] p, input logic h,
                          input logic [5:0] d, input logic [2:0] c, input logic [3:0] l,
                          input logic [MASK_W-1:0] e);
        @(negedge clk);
        drive_req(p, h, d, c, l);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check({tag, " valid"}, 32'(res_valid), 32'd1);
        check(tag, 32'(res_mask), 32'(e));
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Reset state: R13, R1, R2, R10
        @(negedge clk);
        check("R13 idle after reset", 32'(res_valid), 32'd0);
        cfg_check("R1 entry 3",         7'd3,  11'h008);
        cfg_check("R1 entry 59",        7'd59, 11'h400);
        cfg_check("R10 entry 60",       7'd60, 11'h3FF);
        cfg_check("R1 entry 80",        7'd80, 11'h7FE);
        cfg_check("R2 unicast sel",     7'd96, 11'd60);
        cfg_check("R2 multicast sel",   7'd97, 11'd61);
        cfg_check("R2 broadcast sel",   7'd98, 11'd61);

        // Back-to-back vector walk: R3, R4
        for (int k = 0; k < NV + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check($sformatf("R3 vec%0d valid", k - 2), 32'(res_valid), 32'd1);
                check($sformatf("R%0d vec%0d mask", VECS[k-2].req, k - 2),
                      32'(res_mask), 32'(VECS[k-2].exp));
            end
            if (k < NV) drive_req(VECS[k].port, VECS[k].hit, VECS[k].dest,
                                  VECS[k].cls, VECS[k].lac);
            else        req_valid = 1'b0;
        end
        @(negedge clk);
        check("R3 valid drops", 32'(res_valid), 32'd0);

        // R8 aggregation masks
        cfg_write(7'd67, 11'h0F0);
        cfg_check("R12 entry 67 readback", 7'd67, 11'h0F0);
        lookup("R8 lac 3", 4'd0, 1'b1, 6'd61, 3'd0, 4'd3, 11'h0F0);
        lookup("R4 lac 4", 4'd0, 1'b1, 6'd61, 3'd0, 4'd4, 11'h7FE);

        // R9 source mask
        cfg_write(7'd82, 11'h001);
        lookup("R9 source entry", 4'd2, 1'b1, 6'd63, 3'd0, 4'd0, 11'h001);

        // R10 CPU enabled for unknown unicast
        cfg_write(7'd60, 11'h7FF);
        lookup("R10 UC reaches CPU", 4'd0, 1'b0, 6'd0, 3'd0, 4'd0, 11'h7FE);

        // R11 write one cycle after the request: old value
        @(negedge clk);
        drive_req(4'd3, 1'b1, 6'd5, 3'd0, 4'd0);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_addr = 7'd5; cfg_wdata = '0;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R11 late write old", 32'(res_mask), 32'h020);
        lookup("R11 later lookup new", 4'd3, 1'b1, 6'd5, 3'd0, 4'd0, 11'h000);

        // R11 write in the same cycle as the request: new value
        @(negedge clk);
        drive_req(4'd3, 1'b1, 6'd6, 3'd0, 4'd0);
        cfg_we = 1'b1; cfg_addr = 7'd6; cfg_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        check("R11 same-cycle write", 32'(res_mask), 32'h000);

        // R6 flood selection registers, R7 unaffected
        cfg_write(7'd96, 11'd59);
        lookup("R6 UC via reg", 4'd0, 1'b0, 6'd0, 3'd0, 4'd0, 11'h400);
        cfg_write(7'd98, 11'd7);
        lookup("R6 BC via reg", 4'd1, 1'b0, 6'd0, 3'd1, 4'd0, 11'h080);
        cfg_write(7'd97, 11'd20);
        lookup("R6 MC via reg", 4'd1, 1'b0, 6'd0, 3'd2, 4'd0, 11'h000);
        lookup("R7 IPv4 fixed", 4'd1, 1'b0, 6'd0, 3'd3, 4'd0, 11'h7FD);
        cfg_check("R2 UC readback", 7'd96, 11'd59);

        // R12 unmapped addresses
        cfg_write(7'd100, 11'h7FF);
        cfg_write(7'd91, 11'h7FF);
        cfg_check("R12 addr 100 reads 0", 7'd100, 11'h000);
        cfg_check("R12 addr 91 reads 0",  7'd91,  11'h000);
        cfg_check("R12 MC sel kept",      7'd97,  11'd20);
        cfg_check("R12 BC sel kept",      7'd98,  11'd7);

        // R13 reset during a lookup
        @(negedge clk);
        drive_req(4'd0, 1'b1, 6'd0, 3'd0, 4'd0);
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R13 reset kills result", 32'(res_valid), 32'd0);
        rst = 1'b0;
        cfg_check("R2 sel after reset", 7'd96, 11'd60);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule